// File: doc/BRIEF.md
# Event Counter Unit with Threshold Interrupts

This block watches a vector of single-bit hardware event lines and counts them in a bank of wide counters, one counter for each line. Software turns each line on or off with an enable bit. It can load any counter with a starting value and read every counter back through an AXI4-Lite slave port. The block registers the event lines before it counts them, so a pulse shows up in its counter one clock later. Lines of the same kind, for example several commit lanes, stay on separate inputs, and software adds their counts together.

A small set of threshold units sits beside the counters. Each unit takes a mask that picks some of the enabled lines, a target value and a running count of its own. In every cycle the unit adds the number of picked lines that are active. When its count reaches the target, the unit marks its bit as pending and returns its own count to zero, which leaves every other counter alone. If a line is tied high, a unit watching it raises the interrupt at a fixed period. The single interrupt output stays high while any pending bit is set. Software clears a pending bit by writing a one to it.

Top module: `evt_mon_unit`

## Requirements
- R1: After reset, every event counter, the enable word, every mask, every target, every unit count and every pending bit read as zero, and irq_o is low.
- R2: While enable bit i is set, every clock in which the registered copy of evt_i[i] is high adds one to counter i. A pulse is counted one cycle after the edge that samples it. Lines that are high together are each counted in their own counter.
- R3: While enable bit i is clear, counter i holds its value whatever evt_i[i] does.
- R4: A write to the counter word at byte address 0x04*(i+1) loads counter i with the written data. If that write lands in the same cycle as an increment, the write wins. The enable word sits at byte address 0x00, and bit i of it enables line i.
- R5: A counter that holds 0xFFFFFFFF and takes one increment reads 0 afterwards.
- R6: Unit k has its mask at 0x58+12k, its target at 0x5C+12k and its count (read-only) at 0x60+12k. In every cycle it adds the number of lines that are enabled, selected by its mask and high in their registered copy. When the new sum is greater than or equal to a nonzero target, the unit sets pending bit k and its count becomes 0.
- R7: A unit whose target is 0 keeps its count unchanged and never sets its pending bit.
- R8: irq_o is high exactly when some pending bit is set. A read of the status word at 0x54 returns the pending bits, with bit k belonging to unit k. Writing a 1 to bit k clears that bit. If a new hit arrives in the same cycle as the clear, the bit stays set.
- R9: When a line is held high and a unit watches it with target N, the interrupt rises once every N cycles, provided software clears the pending bit between hits.
- R10: Every write and read response is OKAY (code 0). A read of an unmapped address returns 0. Writes to unmapped addresses or to read-only words change nothing. A response stays valid until the master accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Event lines, one bit per counter |
| irq_o | output | 1 | Level interrupt, high while any unit is pending |
| s_awaddr | input | ADDR_W | Write address (byte) |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address (byte) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
The assertions assume a master that presents the write address and write data together and keeps them valid until the ready signal rises. They also assume that reads and writes use word-aligned addresses. The bench only issues whole-word writes with all strobes set, one transaction at a time. It changes the event lines on falling edges, so that every pulse covers a known number of sampling edges. The periodic test clears the pending bit well inside one period, so that a clear never lands on a hit edge.

// File: rtl/evmu_pkg.sv
package evmu_pkg;
   localparam int DATA_W = 32;
   localparam int STRB_W = DATA_W / 8;

   typedef enum logic [1:0] {
      RESP_OKAY   = 2'b00,
      RESP_SLVERR = 2'b10
   } axil_resp_e;

   function automatic logic [DATA_W-1:0] strb_to_mask(input logic [STRB_W-1:0] strb);
      logic [DATA_W-1:0] m;
      for (int b = 0; b < STRB_W; b++) m[b*8 +: 8] = {8{strb[b]}};
      return m;
   endfunction
endpackage

// File: rtl/evmu_axil_slave.sv
module evmu_axil_slave
   import evmu_pkg::*;
#(
   parameter int ADDR_W = 8,
   localparam int WORD_W = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [STRB_W-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   output logic              wr_en_o,
   output logic [WORD_W-1:0] wr_word_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic [DATA_W-1:0] wr_bm_o,
   output logic [WORD_W-1:0] rd_word_o,
   input  logic [DATA_W-1:0] rd_data_i
);
   logic              bvalid_q, rvalid_q;
   logic [DATA_W-1:0] rdata_q;
   logic              wr_hs, rd_hs;
   logic [3:0]        unused_bits;

   assign unused_bits = {awaddr[1:0], araddr[1:0]};

   assign wr_hs   = awvalid && wvalid && !bvalid_q;
   assign awready = wr_hs;
   assign wready  = wr_hs;
   assign rd_hs   = arvalid && !rvalid_q;
   assign arready = !rvalid_q;

   assign wr_en_o   = wr_hs;
   assign wr_word_o = awaddr[ADDR_W-1:2];
   assign wr_data_o = wdata;
   assign wr_bm_o   = strb_to_mask(wstrb);
   assign rd_word_o = araddr[ADDR_W-1:2];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bvalid_q <= 1'b0;
      end else if (wr_hs) begin
         bvalid_q <= 1'b1;
      end else if (bready) begin
         bvalid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else if (rd_hs) begin
         rvalid_q <= 1'b1;
         rdata_q  <= rd_data_i;
      end else if (rready) begin
         rvalid_q <= 1'b0;
      end
   end

   assign bvalid = bvalid_q;
   assign bresp  = RESP_OKAY;
   assign rvalid = rvalid_q;
   assign rdata  = rdata_q;
   assign rresp  = RESP_OKAY;

   AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && !bready |=> bvalid) else $error("write response dropped"); // R10
   AST_R_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && !rready |=> rvalid && $stable(rdata)) else $error("read response dropped"); // R10
endmodule

// File: rtl/evmu_cnt_bank.sv
module evmu_cnt_bank #(
   parameter int NUM_EVT = 20,
   parameter int CNT_W   = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_EVT-1:0]              evt_i,
   input  logic [NUM_EVT-1:0]              en_i,
   input  logic [NUM_EVT-1:0]              wr_sel_i,
   input  logic [CNT_W-1:0]                wr_data_i,
   input  logic [CNT_W-1:0]                wr_bm_i,
   output logic [NUM_EVT-1:0]              evt_q_o,
   output logic [NUM_EVT-1:0][CNT_W-1:0]   cnt_o
);
   logic [NUM_EVT-1:0]            evt_q;
   logic [NUM_EVT-1:0][CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= evt_i;
   end

   for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q[g] <= '0;
         end else if (wr_sel_i[g]) begin
            cnt_q[g] <= (cnt_q[g] & ~wr_bm_i) | (wr_data_i & wr_bm_i);
         end else if (evt_q[g] && en_i[g]) begin
            cnt_q[g] <= cnt_q[g] + CNT_W'(1);
         end
      end

      AST_CNT_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_sel_i[g] && !en_i[g] |=> $stable(cnt_q[g])) else $error("disabled counter moved"); // R3
      AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         !wr_sel_i[g] |=> (cnt_q[g] - $past(cnt_q[g])) <= CNT_W'(1)) else $error("counter jumped"); // R2
   end

   assign evt_q_o = evt_q;
   assign cnt_o   = cnt_q;
endmodule

// File: rtl/evmu_thr_unit.sv
module evmu_thr_unit #(
   parameter int NUM_EVT = 20,
   parameter int CNT_W   = 32,
   localparam int INC_W  = $clog2(NUM_EVT + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_q_i,
   input  logic [NUM_EVT-1:0] mask_i,
   input  logic [CNT_W-1:0]   thr_i,
   output logic [CNT_W-1:0]   cnt_o,
   output logic               hit_o
);
   logic [NUM_EVT-1:0] sel;
   logic [INC_W-1:0]   inc;
   logic [CNT_W:0]     sum;
   logic [CNT_W-1:0]   cnt_q;
   logic               active;

   assign sel    = evt_q_i & mask_i;
   assign active = |thr_i;

   always_comb begin
      inc = '0;
      for (int i = 0; i < NUM_EVT; i++) inc = inc + INC_W'(sel[i]);
   end

   assign sum   = {1'b0, cnt_q} + (CNT_W+1)'(inc);
   assign hit_o = active && (sum >= {1'b0, thr_i});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (active) begin
         if (hit_o) cnt_q <= '0;
         else       cnt_q <= sum[CNT_W-1:0];
      end
   end

   assign cnt_o = cnt_q;

   AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      hit_o |=> cnt_q == '0) else $error("unit count not cleared"); // R6
   AST_THR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      thr_i == '0 |=> $stable(cnt_q)) else $error("idle unit moved"); // R7
endmodule

// File: rtl/evt_mon_unit.sv
module evt_mon_unit
   import evmu_pkg::*;
#(
   parameter int NUM_EVT = 20,
   parameter int CNT_W   = 32,
   parameter int NUM_THR = 4,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_EVT-1:0] evt_i,
   output logic               irq_o,
   input  logic [ADDR_W-1:0]  s_awaddr,
   input  logic               s_awvalid,
   output logic               s_awready,
   input  logic [31:0]        s_wdata,
   input  logic [3:0]         s_wstrb,
   input  logic               s_wvalid,
   output logic               s_wready,
   output logic [1:0]         s_bresp,
   output logic               s_bvalid,
   input  logic               s_bready,
   input  logic [ADDR_W-1:0]  s_araddr,
   input  logic               s_arvalid,
   output logic               s_arready,
   output logic [31:0]        s_rdata,
   output logic [1:0]         s_rresp,
   output logic               s_rvalid,
   input  logic               s_rready
);
   localparam int WORD_W   = ADDR_W - 2;
   localparam int W_ENA    = 0;
   localparam int W_CNT0   = 1;
   localparam int W_STAT   = NUM_EVT + 1;
   localparam int W_THR0   = NUM_EVT + 2;
   localparam int W_LAST   = W_THR0 + 3 * NUM_THR - 1;

   if (NUM_EVT < 1 || NUM_EVT > DATA_W) begin : g_bad_evt
      $error("NUM_EVT must be within 1..32");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("CNT_W must be within 1..32");
   end
   if (NUM_THR < 1 || NUM_THR > DATA_W) begin : g_bad_thr
      $error("NUM_THR must be within 1..32");
   end
   if ((W_LAST + 1) > (1 << WORD_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic              wr_en;
   logic [WORD_W-1:0] wr_word, rd_word;
   logic [DATA_W-1:0] wr_data, wr_bm, rd_data;

   evmu_axil_slave #(.ADDR_W(ADDR_W)) u_axil (
      .clk(clk), .rst_n(rst_n),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
      .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
      .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
      .wr_en_o(wr_en), .wr_word_o(wr_word), .wr_data_o(wr_data), .wr_bm_o(wr_bm),
      .rd_word_o(rd_word), .rd_data_i(rd_data)
   );

   logic [NUM_EVT-1:0]              en_q;
   logic [NUM_THR-1:0][NUM_EVT-1:0] mask_q;
   logic [NUM_THR-1:0][CNT_W-1:0]   thr_q;
   logic [NUM_THR-1:0][CNT_W-1:0]   ucnt;
   logic [NUM_THR-1:0]              pend_q, hit;
   logic [NUM_EVT-1:0]              cnt_sel;
   logic [NUM_EVT-1:0]              evt_q;
   logic [NUM_EVT-1:0][CNT_W-1:0]   cnt;
   logic                            wr_ena, wr_stat;
   logic [NUM_THR-1:0]              wr_mask, wr_thr;

   // Write decode
   always_comb begin
      int wi;
      wi      = int'(wr_word);
      wr_ena  = wr_en && (wi == W_ENA);
      wr_stat = wr_en && (wi == W_STAT);
      for (int i = 0; i < NUM_EVT; i++) cnt_sel[i] = wr_en && (wi == W_CNT0 + i);
      for (int k = 0; k < NUM_THR; k++) begin
         wr_mask[k] = wr_en && (wi == W_THR0 + 3 * k);
         wr_thr[k]  = wr_en && (wi == W_THR0 + 3 * k + 1);
      end
   end

   function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_v,
                                                input logic [DATA_W-1:0] new_v,
                                                input logic [DATA_W-1:0] bm);
      return (old_v & ~bm) | (new_v & bm);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (wr_ena) begin
         en_q <= NUM_EVT'(merge(DATA_W'(en_q), wr_data, wr_bm));
      end
   end

   for (genvar k = 0; k < NUM_THR; k++) begin : g_thr
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mask_q[k] <= '0;
            thr_q[k]  <= '0;
         end else begin
            if (wr_mask[k]) mask_q[k] <= NUM_EVT'(merge(DATA_W'(mask_q[k]), wr_data, wr_bm));
            if (wr_thr[k])  thr_q[k]  <= CNT_W'(merge(DATA_W'(thr_q[k]), wr_data, wr_bm));
         end
      end

      evmu_thr_unit #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_thr (
         .clk(clk), .rst_n(rst_n),
         .evt_q_i(evt_q & en_q), .mask_i(mask_q[k]), .thr_i(thr_q[k]),
         .cnt_o(ucnt[k]), .hit_o(hit[k])
      );
   end

   evmu_cnt_bank #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .evt_i(evt_i), .en_i(en_q),
      .wr_sel_i(cnt_sel), .wr_data_i(wr_data[CNT_W-1:0]), .wr_bm_i(wr_bm[CNT_W-1:0]),
      .evt_q_o(evt_q), .cnt_o(cnt)
   );

   // Pending bits: a hit outranks a clear in the same cycle
   logic [NUM_THR-1:0] clr;
   assign clr = wr_stat ? NUM_THR'(wr_data & wr_bm) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | hit;
   end

   assign irq_o = |pend_q;

   // Read mux
   always_comb begin
      int ri;
      ri      = int'(rd_word);
      rd_data = '0;
      if (ri == W_ENA)  rd_data = DATA_W'(en_q);
      if (ri == W_STAT) rd_data = DATA_W'(pend_q);
      for (int i = 0; i < NUM_EVT; i++)
         if (ri == W_CNT0 + i) rd_data = DATA_W'(cnt[i]);
      for (int k = 0; k < NUM_THR; k++) begin
         if (ri == W_THR0 + 3 * k)     rd_data = DATA_W'(mask_q[k]);
         if (ri == W_THR0 + 3 * k + 1) rd_data = DATA_W'(thr_q[k]);
         if (ri == W_THR0 + 3 * k + 2) rd_data = DATA_W'(ucnt[k]);
      end
   end

   AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|hit)) else $error("interrupt without a hit"); // R8
   AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(wr_stat)) else $error("interrupt dropped without a clear"); // R8
endmodule

// File: tb/tb_evt_mon_unit.sv
`timescale 1ns/1ps
module tb_evt_mon_unit;
   localparam int NE = 20;
   localparam logic [7:0] A_ENA  = 8'h00;
   localparam logic [7:0] A_STAT = 8'h54;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt = '0;
   logic          irq;
   logic [7:0]    awaddr = '0, araddr = '0;
   logic          awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
   logic [31:0]   wdata = '0;
   logic [3:0]    wstrb = 4'hF;
   logic          awready, wready, bvalid, arready, rvalid;
   logic [1:0]    bresp, rresp;
   logic [31:0]   rdata;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   evt_mon_unit dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .irq_o(irq),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
      .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
      .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready)
   );

   function automatic logic [7:0] a_cnt(input int i);  return 8'(4 * (i + 1));    endfunction
   function automatic logic [7:0] a_mask(input int k); return 8'(8'h58 + 12 * k); endfunction
   function automatic logic [7:0] a_thr(input int k);  return 8'(8'h5C + 12 * k); endfunction
   function automatic logic [7:0] a_ucnt(input int k); return 8'(8'h60 + 12 * k); endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
      #1;
      while (!awready) @(negedge clk);
      @(posedge clk); #1;
      awvalid = 0; wvalid = 0; bready = 1;
      while (!bvalid) @(negedge clk);
      check("R10 bresp", 32'(bresp), 32'd0);
      @(posedge clk); #1;
      bready = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      araddr = a; arvalid = 1;
      #1;
      while (!arready) @(negedge clk);
      @(posedge clk); #1;
      arvalid = 0; rready = 1;
      while (!rvalid) @(negedge clk);
      d = rdata;
      check("R10 rresp", 32'(rresp), 32'd0);
      @(posedge clk); #1;
      rready = 0;
   endtask

   task automatic pulse(input logic [NE-1:0] m, input int n);
      @(negedge clk);
      evt = m;
      repeat (n) @(negedge clk);
      evt = '0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      @(negedge clk);
      check("R1 irq", 32'(irq), 0);
      rd(A_ENA, v);     check("R1 enable", v, 0);
      rd(a_cnt(0), v);  check("R1 counter", v, 0);
      rd(A_STAT, v);    check("R1 status", v, 0);
      rd(a_thr(0), v);  check("R1 target", v, 0);
   endtask

   task automatic t_count();
      logic [31:0] v;
      wr(A_ENA, 32'h0000_04FC);
      pulse(20'h000F0, 7);
      for (int i = 4; i < 8; i++) begin
         rd(a_cnt(i), v); check("R2 lane count", v, 7);
      end
      pulse(20'h01000, 4);
      rd(a_cnt(12), v); check("R3 disabled counter", v, 0);
   endtask

   task automatic t_preset_wrap();
      logic [31:0] v;
      wr(a_cnt(10), 32'h1234_5678);
      rd(a_cnt(10), v); check("R4 preset", v, 32'h1234_5678);
      wr(a_cnt(10), 32'hFFFF_FFFF);
      pulse(20'h00400, 1);
      rd(a_cnt(10), v); check("R5 wrap", v, 0);
   endtask

   task automatic t_threshold();
      logic [31:0] v;
      wr(a_mask(0), 32'h0000_000C);
      wr(a_mask(2), 32'h0000_000C);
      wr(a_thr(0), 5);
      pulse(20'h0000C, 3);
      rd(a_ucnt(0), v); check("R6 unit cleared at hit", v, 0);
      rd(A_STAT, v);    check("R8 status pending", v, 1);
      @(negedge clk);   check("R8 irq high", 32'(irq), 1);
      rd(a_ucnt(2), v); check("R7 idle unit count", v, 0);
      wr(a_ucnt(0), 32'h55);
      rd(a_ucnt(0), v); check("R10 read-only word", v, 0);
      wr(A_STAT, 1);
      @(negedge clk);   check("R8 irq cleared", 32'(irq), 0);
      rd(A_STAT, v);    check("R8 status cleared", v, 0);
      pulse(20'h0000C, 1);
      rd(a_ucnt(0), v); check("R6 partial sum", v, 2);
      @(negedge clk);   check("R6 no irq below target", 32'(irq), 0);
      wr(a_thr(0), 0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v;
      rd(8'hFC, v);  check("R10 unmapped read", v, 0);
      wr(8'hF0, 32'hFFFF_FFFF);
      rd(A_ENA, v);  check("R10 unmapped write", v, 32'h0000_04FC);
   endtask

   task automatic t_periodic();
      int t1, t2;
      wr(A_ENA, 32'h0000_04FD);
      wr(a_mask(1), 1);
      wr(a_thr(1), 10);
      @(negedge clk);
      evt[0] = 1'b1;
      while (!irq) @(negedge clk);
      t1 = cyc;
      wr(A_STAT, 2);
      @(negedge clk);
      check("R9 cleared between hits", 32'(irq), 0);
      while (!irq) @(negedge clk);
      t2 = cyc;
      check("R9 period", 32'(t2 - t1), 10);
      evt[0] = 1'b0;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_count();
      t_preset_wrap();
      t_threshold();
      t_unmapped();
      t_periodic();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule